// File: doc/BRIEF.md
# Transmit Buffer Priority Arbiter

This block decides which of several outgoing message buffers a bus controller sends next. Each buffer holds an 8-bit local priority, a 4-bit length code and an empty flag. A host clears the empty flag to mark a buffer as pending. While a buffer is empty and selected, the host may also program its priority and length code. Access is steered by a one-hot select register, so only one buffer can be touched at a time.

When the frame transmitter is about to emit a start of frame, it pulses `pre_sof`. On that pulse the arbiter compares the priorities of all pending buffers. The lowest value wins, and the lower index wins a tie. The arbiter latches the winner's index and decoded byte count and holds them until the transmitter reports completion with `tx_done`. The winning buffer is then marked empty again.

Top module: `txarb_top`

## Requirements
- R1: After reset every empty flag reads 1, the select register reads 0, `win_valid` is 0, and every priority register reads back 0x00 when it is selected.
- R2: A buffer whose empty flag is 1 never becomes the winner, whatever its priority.
- R3: Among pending buffers, the one with the numerically smallest priority becomes the winner.
- R4: When several pending buffers share the smallest priority, the one with the lowest index (bit 0 of the select register is buffer 0) wins.
- R5: `win_valid` rises only in the cycle after a `pre_sof` pulse. Pending buffers added after the pulse do not change the latched winner.
- R6: While `win_valid` is 1, `win_idx` and `win_bytes` stay unchanged and further `pre_sof` pulses are ignored, until `tx_done`.
- R7: A `tx_done` pulse while `win_valid` is 1 drops `win_valid` and sets the winner's empty flag, both visible in the next cycle.
- R8: A `pre_sof` pulse with no pending buffer leaves `win_valid` at 0.
- R9: A priority or length write takes effect only when the select register is one-hot and the selected buffer is empty. `prio_rdata` shows the selected buffer's priority under the same condition and is 0x00 otherwise.
- R10: A `clr_req` pulse clears the empty flag only of the buffer named by a one-hot select value. It has no effect for any other select value.
- R11: `win_bytes` equals the winner's length code for codes 0 to 8 and equals 8 for codes 9 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_wr | input | 1 | Load the buffer-select register |
| sel_wdata | input | 3 | New select value, one bit per buffer |
| prio_wr | input | 1 | Write priority of the selected buffer |
| prio_wdata | input | 8 | Priority write data |
| dlc_wr | input | 1 | Write length code of the selected buffer |
| dlc_wdata | input | 4 | Length code write data |
| clr_req | input | 1 | Mark the selected buffer as pending |
| prio_rdata | output | 8 | Gated priority read-back |
| buf_sel | output | 3 | Current select register |
| empty_flags | output | 3 | Empty flag of each buffer |
| pre_sof | input | 1 | Evaluation strobe before start of frame |
| tx_done | input | 1 | Transmission of the winner finished |
| win_valid | output | 1 | A winner is latched |
| win_idx | output | 2 | Index of the latched winner |
| win_bytes | output | 4 | Data byte count of the latched winner |

## Verification
A fault in the comparison chain shows up as a wrong `win_idx` or `win_bytes` one cycle after the strobe. Across the full sweep of pending masks and priority sets, this includes the tie cases and the clamped length codes. A leaked gated write stays hidden until a later strobe, so the bench programs a blocked value that would have changed the outcome. A flag that fails to refill after `tx_done` appears at `empty_flags` one cycle later. It is also seen when the same buffer wins again on the next strobe.

// File: rtl/txarb_pkg.sv
// Shared constants and the length decode for the transmit arbiter.
// Assumes a 4-bit length code whose byte count saturates at 8.
package txarb_pkg;
    localparam int DLC_W     = 4;
    localparam int MAX_BYTES = 8;

    // Convert a length code to a data byte count, clamping large codes.
    function automatic logic [DLC_W-1:0] dlc_to_bytes(input logic [DLC_W-1:0] code);
        if (code > DLC_W'(MAX_BYTES)) begin
            return DLC_W'(MAX_BYTES);
        end
        return code;
    endfunction
endpackage

// File: rtl/txarb_regs.sv
// Per-buffer register file: priority, length code and empty flag.
// Host access is allowed only on a one-hot select naming an empty buffer.
// Assumes the winner latch reports completion through done_set.
module txarb_regs
    import txarb_pkg::*;
#(
    parameter int NUM_BUF = 3,
    parameter int PRIO_W  = 8,
    parameter int IDX_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           sel_wr,
    input  logic [NUM_BUF-1:0]             sel_wdata,
    input  logic                           prio_wr,
    input  logic [PRIO_W-1:0]              prio_wdata,
    input  logic                           dlc_wr,
    input  logic [DLC_W-1:0]               dlc_wdata,
    input  logic                           clr_req,
    input  logic                           done_set,
    input  logic [IDX_W-1:0]               done_idx,
    output logic [NUM_BUF-1:0]             sel_q,
    output logic [NUM_BUF-1:0]             empty_q,
    output logic [NUM_BUF-1:0][PRIO_W-1:0] prio_q,
    output logic [NUM_BUF-1:0][DLC_W-1:0]  dlc_q,
    output logic [PRIO_W-1:0]              rdata
);
    logic              sel_one;
    logic [NUM_BUF-1:0] hit;
    logic [NUM_BUF-1:0] acc;

    // Select register update.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else if (sel_wr) sel_q <= sel_wdata;
    end

    // Decide whether the select value names exactly one buffer.
    always_comb begin
        sel_one = (sel_q != '0) && ((sel_q & (sel_q - NUM_BUF'(1))) == '0);
    end

    for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
        // Selection and access qualifiers for this buffer.
        always_comb begin
            hit[g] = sel_one && sel_q[g];
            acc[g] = hit[g] && empty_q[g];
        end

        // Priority register, writable only when access is granted.
        always_ff @(posedge clk) begin
            if (!rst_n) prio_q[g] <= '0;
            else if (prio_wr && acc[g]) prio_q[g] <= prio_wdata;
        end

        // Length code register, same gating as the priority.
        always_ff @(posedge clk) begin
            if (!rst_n) dlc_q[g] <= '0;
            else if (dlc_wr && acc[g]) dlc_q[g] <= dlc_wdata;
        end

        // Empty flag: refilled on completion, cleared by host request.
        always_ff @(posedge clk) begin
            if (!rst_n) empty_q[g] <= 1'b1;
            else if (done_set && (done_idx == IDX_W'(g))) empty_q[g] <= 1'b1;
            else if (clr_req && hit[g]) empty_q[g] <= 1'b0;
        end
    end

    // Gated read-back: only the accessible buffer contributes.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_BUF; i++) begin
            if (acc[i]) rdata = rdata | prio_q[i];
        end
    end
endmodule

// File: rtl/txarb_pick.sv
// Combinational minimum finder over the pending buffers.
// A linear chain in index order; strict less-than keeps the lower index on ties.
module txarb_pick
    import txarb_pkg::*;
#(
    parameter int NUM_BUF = 3,
    parameter int PRIO_W  = 8,
    parameter int IDX_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic [NUM_BUF-1:0]             pend,
    input  logic [NUM_BUF-1:0][PRIO_W-1:0] prio,
    input  logic [NUM_BUF-1:0][DLC_W-1:0]  dlc,
    output logic                           any,
    output logic [IDX_W-1:0]               idx,
    output logic [DLC_W-1:0]               code
);
    logic [NUM_BUF:0]               any_c;
    logic [NUM_BUF:0][PRIO_W-1:0]   best_c;
    logic [NUM_BUF:0][IDX_W-1:0]    idx_c;
    logic [NUM_BUF:0][DLC_W-1:0]    dlc_c;

    // Chain seed: nothing found yet.
    always_comb begin
        any_c[0]  = 1'b0;
        best_c[0] = '0;
        idx_c[0]  = '0;
        dlc_c[0]  = '0;
    end

    for (genvar g = 0; g < NUM_BUF; g++) begin : g_stage
        logic take;
        // Stage g replaces the running best only with a strictly smaller pending value.
        always_comb begin
            take        = pend[g] && (!any_c[g] || (prio[g] < best_c[g]));
            any_c[g+1]  = any_c[g] | pend[g];
            best_c[g+1] = take ? prio[g] : best_c[g];
            idx_c[g+1]  = take ? IDX_W'(g) : idx_c[g];
            dlc_c[g+1]  = take ? dlc[g] : dlc_c[g];
        end
    end

    // Chain result.
    always_comb begin
        any  = any_c[NUM_BUF];
        idx  = idx_c[NUM_BUF];
        code = dlc_c[NUM_BUF];
    end
endmodule

// File: rtl/txarb_hold.sv
// Winner latch: captures the chosen buffer on the strobe and holds it
// until completion. Assumes the transmitter issues tx_done only for a held winner.
module txarb_hold
    import txarb_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_sof,
    input  logic              tx_done,
    input  logic              cand_any,
    input  logic [IDX_W-1:0]  cand_idx,
    input  logic [DLC_W-1:0]  cand_code,
    output logic              valid,
    output logic [IDX_W-1:0]  idx,
    output logic [DLC_W-1:0]  bytes,
    output logic              done_set
);
    // Completion is honoured only while a winner is held.
    always_comb begin
        done_set = valid && tx_done;
    end

    // Capture on strobe when idle, release on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            idx   <= '0;
            bytes <= '0;
        end else if (done_set) begin
            valid <= 1'b0;
        end else if (pre_sof && !valid && cand_any) begin
            valid <= 1'b1;
            idx   <= cand_idx;
            bytes <= dlc_to_bytes(cand_code);
        end
    end
endmodule

// File: rtl/txarb_top.sv
// Transmit buffer priority arbiter top: register file, minimum finder, winner latch.
// Assumes pre_sof is a single-cycle pulse from the frame transmitter.
module txarb_top
    import txarb_pkg::*;
#(
    parameter int NUM_BUF = 3,
    parameter int PRIO_W  = 8,
    localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_wr,
    input  logic [NUM_BUF-1:0] sel_wdata,
    input  logic               prio_wr,
    input  logic [PRIO_W-1:0]  prio_wdata,
    input  logic               dlc_wr,
    input  logic [DLC_W-1:0]   dlc_wdata,
    input  logic               clr_req,
    output logic [PRIO_W-1:0]  prio_rdata,
    output logic [NUM_BUF-1:0] buf_sel,
    output logic [NUM_BUF-1:0] empty_flags,
    input  logic               pre_sof,
    input  logic               tx_done,
    output logic               win_valid,
    output logic [IDX_W-1:0]   win_idx,
    output logic [DLC_W-1:0]   win_bytes
);
    logic [NUM_BUF-1:0][PRIO_W-1:0] prio_q;
    logic [NUM_BUF-1:0][DLC_W-1:0]  dlc_q;
    logic                           done_set;
    logic                           cand_any;
    logic [IDX_W-1:0]               cand_idx;
    logic [DLC_W-1:0]               cand_code;

    txarb_regs #(.NUM_BUF(NUM_BUF), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_wr     (sel_wr),
        .sel_wdata  (sel_wdata),
        .prio_wr    (prio_wr),
        .prio_wdata (prio_wdata),
        .dlc_wr     (dlc_wr),
        .dlc_wdata  (dlc_wdata),
        .clr_req    (clr_req),
        .done_set   (done_set),
        .done_idx   (win_idx),
        .sel_q      (buf_sel),
        .empty_q    (empty_flags),
        .prio_q     (prio_q),
        .dlc_q      (dlc_q),
        .rdata      (prio_rdata)
    );

    txarb_pick #(.NUM_BUF(NUM_BUF), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick (
        .pend (~empty_flags),
        .prio (prio_q),
        .dlc  (dlc_q),
        .any  (cand_any),
        .idx  (cand_idx),
        .code (cand_code)
    );

    txarb_hold #(.IDX_W(IDX_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .pre_sof   (pre_sof),
        .tx_done   (tx_done),
        .cand_any  (cand_any),
        .cand_idx  (cand_idx),
        .cand_code (cand_code),
        .valid     (win_valid),
        .idx       (win_idx),
        .bytes     (win_bytes),
        .done_set  (done_set)
    );
endmodule

// File: rtl/txarb_chk.sv
// Protocol checker for the arbiter, attached to the top by bind.
module txarb_chk #(
    parameter int NUM_BUF = 3,
    parameter int PRIO_W  = 8,
    parameter int IDX_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clr_req,
    input logic [PRIO_W-1:0]  prio_rdata,
    input logic [NUM_BUF-1:0] buf_sel,
    input logic [NUM_BUF-1:0] empty_flags,
    input logic               pre_sof,
    input logic               tx_done,
    input logic               win_valid,
    input logic [IDX_W-1:0]   win_idx,
    input logic [3:0]         win_bytes
);
    // A held winner stays stable until completion (R6).
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !tx_done) |=> (win_valid && $stable(win_idx) && $stable(win_bytes)));

    // The held winner is a pending buffer (R2).
    p_winner_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (((empty_flags >> win_idx) & NUM_BUF'(1)) == '0));

    // Byte count never exceeds eight (R11).
    p_bytes_max_r11: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (win_bytes <= 4'd8));

    // A winner appears only after a strobe (R5).
    p_rise_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_valid) |-> $past(pre_sof));

    // Completion releases the winner and refills its flag (R7).
    p_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && tx_done) |=>
            (!win_valid && (((empty_flags >> $past(win_idx)) & NUM_BUF'(1)) != '0)));

    // Read-back is zero without a one-hot select (R9).
    p_read_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$onehot(buf_sel) |-> (prio_rdata == '0));

    // Clear request without a one-hot select changes no flag (R10).
    p_clr_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !$onehot(buf_sel) && !tx_done) |=> (empty_flags == $past(empty_flags)));
endmodule

bind txarb_top txarb_chk #(.NUM_BUF(NUM_BUF), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_req     (clr_req),
    .prio_rdata  (prio_rdata),
    .buf_sel     (buf_sel),
    .empty_flags (empty_flags),
    .pre_sof     (pre_sof),
    .tx_done     (tx_done),
    .win_valid   (win_valid),
    .win_idx     (win_idx),
    .win_bytes   (win_bytes)
);

// File: tb/test_txarb_top.sv
`timescale 1ns/1ps
module test_txarb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       sel_wr, prio_wr, dlc_wr, clr_req, pre_sof, tx_done;
    logic [2:0] sel_wdata;
    logic [7:0] prio_wdata;
    logic [3:0] dlc_wdata;
    logic [7:0] prio_rdata;
    logic [2:0] buf_sel, empty_flags;
    logic       win_valid;
    logic [1:0] win_idx;
    logic [3:0] win_bytes;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    txarb_top i_txarb_top (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .prio_wr(prio_wr), .prio_wdata(prio_wdata), .dlc_wr(dlc_wr),
        .dlc_wdata(dlc_wdata), .clr_req(clr_req), .prio_rdata(prio_rdata),
        .buf_sel(buf_sel), .empty_flags(empty_flags), .pre_sof(pre_sof),
        .tx_done(tx_done), .win_valid(win_valid), .win_idx(win_idx),
        .win_bytes(win_bytes)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_sel(input logic [2:0] v);
        @(negedge clk) sel_wr = 1'b1; sel_wdata = v;
        @(negedge clk) sel_wr = 1'b0;
    endtask
    task automatic wr_prio(input logic [7:0] v);
        @(negedge clk) prio_wr = 1'b1; prio_wdata = v;
        @(negedge clk) prio_wr = 1'b0;
    endtask
    task automatic wr_dlc(input logic [3:0] v);
        @(negedge clk) dlc_wr = 1'b1; dlc_wdata = v;
        @(negedge clk) dlc_wr = 1'b0;
    endtask
    task automatic clr();
        @(negedge clk) clr_req = 1'b1;
        @(negedge clk) clr_req = 1'b0;
    endtask
    task automatic strobe();
        @(negedge clk) pre_sof = 1'b1;
        @(negedge clk) pre_sof = 1'b0;
    endtask
    task automatic done();
        @(negedge clk) tx_done = 1'b1;
        @(negedge clk) tx_done = 1'b0;
    endtask

    function automatic int bytes_of(input int c);
        return (c > 8) ? 8 : c;
    endfunction

    // Full round for one pending mask and priority/length set.
    task automatic run_case(input int mask, input int p[3], input int d[3]);
        int pend;
        for (int b = 0; b < 3; b++) begin
            set_sel(3'(1 << b));
            wr_prio(8'(p[b]));
            wr_dlc(4'(d[b]));
            if (mask[b]) clr();
        end
        check("R10", empty_flags, 7 & ~mask);
        pend = mask;
        for (int round = 0; round < 4; round++) begin
            int best, nbest;
            string tag;
            strobe();
            best = -1; nbest = 0;
            for (int i = 0; i < 3; i++)
                if (pend[i] && (best < 0 || p[i] < p[best])) best = i;
            for (int i = 0; i < 3; i++)
                if (best >= 0 && pend[i] && p[i] == p[best]) nbest++;
            if (best < 0) begin
                check("R8", win_valid, 0);
                break;
            end
            tag = (nbest > 1) ? "R4" : ((pend != 7) ? "R2" : "R3");
            check(tag, win_valid, 1);
            check(tag, win_idx, best);
            check("R11", win_bytes, bytes_of(d[best]));
            strobe();
            check("R6", win_idx, best);
            done();
            pend = pend & ~(1 << best);
            check("R7", win_valid, 0);
            check("R7", empty_flags, 7 & ~pend);
        end
    endtask

    initial begin
        int vals[4] = '{0, 1, 7, 255};
        rst_n = 1'b0; sel_wr = 0; prio_wr = 0; dlc_wr = 0; clr_req = 0;
        pre_sof = 0; tx_done = 0; sel_wdata = 0; prio_wdata = 0; dlc_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", empty_flags, 7);
        check("R1", buf_sel, 0);
        check("R1", win_valid, 0);
        for (int b = 0; b < 3; b++) begin
            set_sel(3'(1 << b));
            check("R1", prio_rdata, 0);
        end

        // Sweep every pending mask against priority sets with ties.
        for (int m = 0; m < 8; m++)
            for (int a = 0; a < 4; a++)
                for (int b = 0; b < 4; b++)
                    for (int c = 0; c < 4; c++) begin
                        int p[3];
                        int d[3];
                        p[0] = vals[a]; p[1] = vals[b]; p[2] = vals[c];
                        for (int k = 0; k < 3; k++) d[k] = (m * 7 + a * 5 + b * 3 + c + k * 6) % 16;
                        run_case(m, p, d);
                    end

        // Access gating with values that would change the outcome if leaked.
        set_sel(3'b001); wr_prio(8'd10); wr_dlc(4'd3); clr();
        wr_prio(8'd0);
        check("R9", prio_rdata, 0);
        set_sel(3'b010); wr_prio(8'd20); wr_dlc(4'd5);
        check("R9", prio_rdata, 20);
        set_sel(3'b011); wr_prio(8'd0); wr_dlc(4'd0);
        check("R9", prio_rdata, 0);
        clr();
        check("R10", empty_flags, 3'b110);
        set_sel(3'b100); wr_prio(8'd30);
        set_sel(3'b010); clr();
        check("R10", empty_flags, 3'b100);
        repeat (5) @(negedge clk);
        check("R5", win_valid, 0);
        strobe();
        check("R9", win_idx, 0);
        check("R9", win_bytes, 3);
        set_sel(3'b100); wr_prio(8'd0); wr_dlc(4'd12); clr();
        strobe();
        check("R5", win_idx, 0);
        check("R6", win_bytes, 3);
        done();
        strobe();
        check("R3", win_idx, 2);
        check("R11", win_bytes, 8);
        done();
        strobe();
        check("R3", win_idx, 1);
        check("R11", win_bytes, 5);
        done();
        strobe();
        check("R8", win_valid, 0);
        check("R7", empty_flags, 7);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule